// File: doc/BRIEF.md
# Palette Expander

The palette expander fills a colour lookup table from a stream of 32-bit palette words and turns every entry into a 24-bit red/green/blue value with a one-bit transparency flag. A 3-bit depth code sets how many entries one load holds. A 2-bit layout selector chooses how a word is split into colour channels. A monochrome bit copies the low byte of the word into all three channels.

Words come in over a valid/ready stream. The first word accepted while the block is idle starts a load. Each accepted word is then stored twice: once as raw source bits, and once as a converted entry in a shadow bank. The shadow bank becomes visible only when the last entry of the load has been written. A one-cycle registered read port returns the converted entry for a pixel index.

The block remembers which layout the visible table was converted with. When a frame-start pulse arrives with a different layout selected, it rebuilds the table from the stored raw words. This pass writes the shadow bank and swaps it in at the end, in the same way as a load.

Top module: `pal_expander`

## Requirements
- R1: The depth code sets the number of entries in a load: code 1 gives 4 entries, code 2 gives 16 and code 3 gives 256. After the last word of a load, index i (below that count) returns the entry built from the i-th word of the load.
- R2: While the block is idle, wordReady is high for every depth code. A word sent with depth codes 0 or 4 to 7 is accepted and dropped: palBusy stays low and every lookup result is unchanged.
- R3: Layout 0 takes red from word bits 15:11, green from bits 10:5 and blue from bits 4:0. Each field is placed at the top of its 8-bit channel, and the low bits are zero. The transparency flag is always 0.
- R4: Layout 1 splits the colour bits as layout 0 does, and takes the transparency flag from word bit 24.
- R5: Layout 2 takes red from bits 23:19, green from bits 15:10 and blue from bits 7:3, each placed at the top of its channel with the low bits zero. The transparency flag comes from bit 24.
- R6: Layout 3 takes red from bits 23:16, green from bits 15:8 and blue from bits 7:0, and the transparency flag from bit 24.
- R7: With monoEn set, red, green and blue all equal word bits 7:0, whatever the layout. The transparency flag follows the layout's own rule.
- R8: A frameStart pulse in idle, with a table loaded and palFmtSel different from the layout the visible table was built with, starts a rebuild from the stored raw words. palBusy is high during the rebuild, and afterwards the entries follow the new layout. With the layout unchanged, frameStart has no effect and palBusy stays low.
- R9: A lookup at an index at or above the current entry count returns the entry at index 0.
- R10: palBusy goes high on the cycle after the first word of a load is accepted. It stays high until the edge that writes the last entry. While a load or a rebuild is in progress, lookups return the table that was visible before it began.
- R11: After reset, palBusy is low, wordReady is high, and every lookup returns all zeros with the transparency flag clear until a load completes.
- R12: lookupRgb and lookupAlpha show the entry for the lookupIdx sampled at the previous rising clock edge.
- R13: wordReady is low for the whole of a rebuild.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depthSel | input | 3 | Pixel depth code (1: 2 bpp, 2: 4 bpp, 3: 8 bpp, other: no table) |
| palFmtSel | input | 2 | Palette word layout, taken from bits 16:15 of the display control word |
| monoEn | input | 1 | Monochrome mode: all channels take the low byte |
| frameStart | input | 1 | One-cycle pulse before a frame is drawn |
| wordValid | input | 1 | Palette word valid |
| wordData | input | 32 | Palette word |
| wordReady | output | 1 | Palette word accepted when high together with wordValid |
| palBusy | output | 1 | Load or rebuild in progress |
| lookupIdx | input | 8 | Pixel index to look up |
| lookupRgb | output | 24 | Converted entry: red 23:16, green 15:8, blue 7:0 |
| lookupAlpha | output | 1 | Transparency flag of the converted entry |

## Verification
The assertions assume that frameStart arrives while no word is being offered, and that lookups are not expected to see entries from a load or rebuild that is still in progress. They also assume that only the hidden bank is ever written. The bench meets these assumptions as follows. It drives every input on the falling clock edge. It raises frameStart only when wordValid is low. It changes depthSel, palFmtSel and monoEn only between loads. It reads results one full cycle after it sets the index.

// File: rtl/pal_expander_pkg.sv
package pal_expander_pkg;

  localparam int PAL_IDX_W   = 8;
  localparam int PAL_ENTRIES = 1 << PAL_IDX_W;
  localparam int PAL_CNT_W   = PAL_IDX_W + 1;
  localparam int CHAN_W      = 8;
  localparam int SRC_W       = 25;          // bits of a word the layouts use
  localparam int ALPHA_BIT   = 24;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_REBUILD
  } palState_e;

  typedef struct packed {
    logic [CHAN_W-1:0] red;
    logic [CHAN_W-1:0] green;
    logic [CHAN_W-1:0] blue;
    logic              alpha;
  } palEntry_t;

  typedef struct packed {
    logic                 rawWe;
    logic                 cvtWe;
    logic                 fromRaw;
    logic                 swap;
    logic [PAL_IDX_W-1:0] idx;
    logic [1:0]           fmt;
    logic                 mono;
    logic [PAL_CNT_W-1:0] count;
  } palStrobe_t;

  function automatic logic [PAL_CNT_W-1:0] entriesFor(input logic [2:0] depth);
    case (depth)
      3'd1:    return PAL_CNT_W'(4);
      3'd2:    return PAL_CNT_W'(16);
      3'd3:    return PAL_CNT_W'(PAL_ENTRIES);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/pal_expander_fmt.sv
module pal_expander_fmt
  import pal_expander_pkg::*;
(
  input  logic [SRC_W-1:0] srcWord,
  input  logic [1:0]       fmtSel,
  input  logic             monoMode,
  output palEntry_t        entry
);

  always_comb begin
    entry.alpha = (fmtSel == 2'd0) ? 1'b0 : srcWord[ALPHA_BIT];
    case (fmtSel)
      2'd2: begin
        entry.red   = {srcWord[23:19], 3'b000};
        entry.green = {srcWord[15:10], 2'b00};
        entry.blue  = {srcWord[7:3],   3'b000};
      end
      2'd3: begin
        entry.red   = srcWord[23:16];
        entry.green = srcWord[15:8];
        entry.blue  = srcWord[7:0];
      end
      default: begin
        entry.red   = {srcWord[15:11], 3'b000};
        entry.green = {srcWord[10:5],  2'b00};
        entry.blue  = {srcWord[4:0],   3'b000};
      end
    endcase
    if (monoMode) begin
      entry.red   = srcWord[CHAN_W-1:0];
      entry.green = srcWord[CHAN_W-1:0];
      entry.blue  = srcWord[CHAN_W-1:0];
    end
  end

endmodule

// File: rtl/pal_expander_ctrl.sv
module pal_expander_ctrl
  import pal_expander_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] depthSel,
  input  logic [1:0] palFmtSel,
  input  logic       monoEn,
  input  logic       frameStart,
  input  logic       wordValid,
  output logic       wordReady,
  output logic       palBusy,
  output palStrobe_t strb
);

  palState_e            state;
  logic [PAL_IDX_W-1:0] idxCnt;
  logic [PAL_CNT_W-1:0] passCount;
  logic [PAL_CNT_W-1:0] curCount;
  logic [1:0]           passFmt;
  logic                 passMono;
  logic [1:0]           usedFmt;

  logic [PAL_CNT_W-1:0] depthCount;
  logic                 startLoad;
  logic                 startRebuild;
  logic                 lastEntry;

  always_comb begin
    depthCount   = entriesFor(depthSel);
    wordReady    = (state != ST_REBUILD);
    palBusy      = (state != ST_IDLE);
    startLoad    = (state == ST_IDLE) && wordValid && (depthCount != '0);
    startRebuild = (state == ST_IDLE) && !wordValid && frameStart &&
                   (curCount != '0) && (palFmtSel != usedFmt);
    lastEntry    = ({1'b0, idxCnt} == (passCount - PAL_CNT_W'(1)));

    strb = '0;
    if (startLoad) begin
      strb.rawWe = 1'b1;
      strb.cvtWe = 1'b1;
      strb.idx   = '0;
      strb.fmt   = palFmtSel;
      strb.mono  = monoEn;
    end else if (state == ST_LOAD && wordValid) begin
      strb.rawWe = 1'b1;
      strb.cvtWe = 1'b1;
      strb.idx   = idxCnt;
      strb.fmt   = passFmt;
      strb.mono  = passMono;
      strb.swap  = lastEntry;
      strb.count = passCount;
    end else if (state == ST_REBUILD) begin
      strb.cvtWe   = 1'b1;
      strb.fromRaw = 1'b1;
      strb.idx     = idxCnt;
      strb.fmt     = passFmt;
      strb.mono    = passMono;
      strb.swap    = lastEntry;
      strb.count   = passCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idxCnt    <= '0;
      passCount <= '0;
      curCount  <= '0;
      passFmt   <= 2'd0;
      passMono  <= 1'b0;
      usedFmt   <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startLoad) begin
            state     <= ST_LOAD;
            idxCnt    <= PAL_IDX_W'(1);
            passFmt   <= palFmtSel;
            passMono  <= monoEn;
            passCount <= depthCount;
          end else if (startRebuild) begin
            state     <= ST_REBUILD;
            idxCnt    <= '0;
            passFmt   <= palFmtSel;
            passMono  <= monoEn;
            passCount <= curCount;
          end
        end
        ST_LOAD: begin
          if (wordValid) begin
            if (lastEntry) begin
              state    <= ST_IDLE;
              usedFmt  <= passFmt;
              curCount <= passCount;
            end else begin
              idxCnt <= idxCnt + PAL_IDX_W'(1);
            end
          end
        end
        ST_REBUILD: begin
          if (lastEntry) begin
            state   <= ST_IDLE;
            usedFmt <= passFmt;
          end else begin
            idxCnt <= idxCnt + PAL_IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Once busy, the block stays busy until the bank swap of the pass
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (palBusy && !strb.swap) |=> palBusy);

  // Unchanged layout: a frame start leaves the block idle
  assert_same_fmt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!palBusy && frameStart && !wordValid && palFmtSel == usedFmt) |=> !palBusy);

  // A rebuild that starts closes the word stream
  assert_rebuild_closes_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!palBusy && frameStart && !wordValid && palFmtSel != usedFmt && curCount != '0)
      |=> !wordReady);

  // Words at an unsupported depth never start a load
  assert_drop_unsupported_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!palBusy && wordValid && entriesFor(depthSel) == '0) |=> !palBusy);

endmodule

// File: rtl/pal_expander_dp.sv
module pal_expander_dp
  import pal_expander_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  palStrobe_t           strb,
  input  logic [SRC_W-1:0]     wordIn,
  input  logic [PAL_IDX_W-1:0] lookupIdx,
  output palEntry_t            lookupOut
);

  logic [SRC_W-1:0]     rawMem  [PAL_ENTRIES];
  palEntry_t            bankMem [2][PAL_ENTRIES];
  logic                 activeBank;
  logic [PAL_CNT_W-1:0] activeCount;

  logic [SRC_W-1:0]     convSrc;
  palEntry_t            cvtEntry;
  logic [PAL_IDX_W-1:0] effIdx;
  logic                 hiddenBank;

  assign convSrc    = strb.fromRaw ? rawMem[strb.idx] : wordIn;
  assign hiddenBank = ~activeBank;

  pal_expander_fmt u_fmt (
    .srcWord (convSrc),
    .fmtSel  (strb.fmt),
    .monoMode(strb.mono),
    .entry   (cvtEntry)
  );

  always_ff @(posedge clk) begin
    if (strb.rawWe) rawMem[strb.idx] <= wordIn;
    if (strb.cvtWe) bankMem[hiddenBank][strb.idx] <= cvtEntry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeBank  <= 1'b0;
      activeCount <= '0;
    end else if (strb.swap) begin
      activeBank  <= hiddenBank;
      activeCount <= strb.count;
    end
  end

  assign effIdx = ({1'b0, lookupIdx} < activeCount) ? lookupIdx : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                  lookupOut <= '0;
    else if (activeCount == '0)  lookupOut <= '0;
    else                         lookupOut <= bankMem[activeBank][effIdx];
  end

  // A completed pass always leaves a legal entry count visible
  assert_count_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.swap |=> (activeCount == PAL_CNT_W'(4) || activeCount == PAL_CNT_W'(16) ||
                   activeCount == PAL_CNT_W'(PAL_ENTRIES)));

  // Writes go to the hidden bank only: without a swap the visible result holds
  assert_hold_prev_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(lookupIdx) && !$past(strb.swap)) |=> $stable(lookupOut));

  // Monochrome entries carry one value on all three channels
  assert_mono_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.cvtWe && strb.mono) |->
      (cvtEntry.red == cvtEntry.green && cvtEntry.green == cvtEntry.blue));

endmodule

// File: rtl/pal_expander.sv
module pal_expander
  import pal_expander_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  depthSel,
  input  logic [1:0]  palFmtSel,
  input  logic        monoEn,
  input  logic        frameStart,
  input  logic        wordValid,
  input  logic [31:0] wordData,
  output logic        wordReady,
  output logic        palBusy,
  input  logic [7:0]  lookupIdx,
  output logic [23:0] lookupRgb,
  output logic        lookupAlpha
);

  palStrobe_t strb;
  palEntry_t  lookupOut;
  logic       unusedHi;

  assign unusedHi = ^wordData[31:SRC_W];

  pal_expander_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .depthSel  (depthSel),
    .palFmtSel (palFmtSel),
    .monoEn    (monoEn),
    .frameStart(frameStart),
    .wordValid (wordValid),
    .wordReady (wordReady),
    .palBusy   (palBusy),
    .strb      (strb)
  );

  pal_expander_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .wordIn   (wordData[SRC_W-1:0]),
    .lookupIdx(lookupIdx),
    .lookupOut(lookupOut)
  );

  assign lookupRgb   = {lookupOut.red, lookupOut.green, lookupOut.blue};
  assign lookupAlpha = lookupOut.alpha;

endmodule

// File: tb/pal_expander_tb.sv
`timescale 1ns/1ps
module pal_expander_tb;

  typedef struct packed {
    logic [1:0]  fmt;
    logic        mono;
    logic [31:0] word;
    logic [23:0] rgb;
    logic        alpha;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 32'h0100F81F, 24'hF800F8, 1'b0},
    '{2'd1, 1'b0, 32'h010007E0, 24'h00FC00, 1'b1},
    '{2'd1, 1'b0, 32'h00008410, 24'h808080, 1'b0},
    '{2'd2, 1'b0, 32'h01FFFFFF, 24'hF8FCF8, 1'b1},
    '{2'd2, 1'b0, 32'h00870C0C, 24'h800C08, 1'b0},
    '{2'd3, 1'b0, 32'h01123456, 24'h123456, 1'b1},
    '{2'd3, 1'b0, 32'h00ABCDEF, 24'hABCDEF, 1'b0},
    '{2'd0, 1'b1, 32'h01001234, 24'h343434, 1'b0},
    '{2'd3, 1'b1, 32'h01FFFF5A, 24'h5A5A5A, 1'b1},
    '{2'd2, 1'b1, 32'h000000C3, 24'hC3C3C3, 1'b0},
    '{2'd1, 1'b1, 32'h0100FFA5, 24'hA5A5A5, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  depthSel = 3'd0;
  logic [1:0]  palFmtSel = 2'd0;
  logic        monoEn = 1'b0;
  logic        frameStart = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = 32'h0;
  logic        wordReady;
  logic        palBusy;
  logic [7:0]  lookupIdx = 8'd0;
  logic [23:0] lookupRgb;
  logic        lookupAlpha;

  int checks = 0;
  int errors = 0;
  logic [31:0] wordBuf [256];

  always #2.5 clk = ~clk;

  pal_expander u_dut (
    .clk(clk), .rst_n(rst_n), .depthSel(depthSel), .palFmtSel(palFmtSel),
    .monoEn(monoEn), .frameStart(frameStart), .wordValid(wordValid),
    .wordData(wordData), .wordReady(wordReady), .palBusy(palBusy),
    .lookupIdx(lookupIdx), .lookupRgb(lookupRgb), .lookupAlpha(lookupAlpha)
  );

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic checkVal(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic lookupCheck(string req, int idx, logic [23:0] expRgb, logic expAlpha);
    @(negedge clk) lookupIdx = 8'(idx);
    @(negedge clk);
    checkVal(req, $sformatf("rgb[%0d]", idx), {8'h0, lookupRgb}, {8'h0, expRgb});
    checkVal(req, $sformatf("alpha[%0d]", idx), {31'h0, lookupAlpha}, {31'h0, expAlpha});
  endtask

  task automatic sendRange(int first, int last);
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      wordValid = 1'b1;
      wordData  = wordBuf[i];
    end
    @(negedge clk) wordValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 1000; n++) begin
      if (!palBusy) break;
      @(negedge clk);
    end
  endtask

  function automatic string reqFor(logic [1:0] fmt, logic mono);
    if (mono) return "R7";
    case (fmt)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual running expected finished");
    finishRun();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    checkVal("R11", "busy", {31'h0, palBusy}, 32'h0);
    checkVal("R11", "ready", {31'h0, wordReady}, 32'h1);
    checkVal("R11", "rgb", {8'h0, lookupRgb}, 32'h0);
    rst_n = 1'b1;
    lookupCheck("R11", 5, 24'h0, 1'b0);

    // Layout table: each vector loads a 4-entry table of one word
    for (int v = 0; v < NVEC; v++) begin
      depthSel  = 3'd1;
      palFmtSel = VECS[v].fmt;
      monoEn    = VECS[v].mono;
      for (int k = 0; k < 4; k++) wordBuf[k] = VECS[v].word;
      sendRange(0, 3);
      lookupCheck(reqFor(VECS[v].fmt, VECS[v].mono), 2, VECS[v].rgb, VECS[v].alpha);
    end

    // R2: unsupported depth drops words
    depthSel  = 3'd0;
    palFmtSel = 2'd3;
    monoEn    = 1'b0;
    @(negedge clk);
    wordValid = 1'b1;
    wordData  = 32'h00FFFFFF;
    #1 checkVal("R2", "ready", {31'h0, wordReady}, 32'h1);
    @(negedge clk) depthSel = 3'd5;
    @(negedge clk) wordValid = 1'b0;
    checkVal("R2", "busy", {31'h0, palBusy}, 32'h0);
    lookupCheck("R2", 2, 24'hA5A5A5, 1'b1);
    lookupCheck("R2", 0, 24'hA5A5A5, 1'b1);

    // R1 / R9 / R10: 16-entry load split by a pause
    depthSel = 3'd2;
    for (int i = 0; i < 16; i++)
      wordBuf[i] = {8'h00, 8'(i), 8'(8'h40 + i), 8'(8'hF0 - i)};
    sendRange(0, 0);
    checkVal("R10", "busy after first word", {31'h0, palBusy}, 32'h1);
    sendRange(1, 4);
    lookupCheck("R10", 2, 24'hA5A5A5, 1'b1);
    lookupCheck("R10", 10, 24'hA5A5A5, 1'b1);
    checkVal("R10", "busy mid load", {31'h0, palBusy}, 32'h1);
    sendRange(5, 15);
    checkVal("R10", "busy after last", {31'h0, palBusy}, 32'h0);
    lookupCheck("R1", 15, 24'h0F4FE1, 1'b0);
    lookupCheck("R1", 5, 24'h0545EB, 1'b0);
    lookupCheck("R9", 16, 24'h0040F0, 1'b0);
    lookupCheck("R9", 200, 24'h0040F0, 1'b0);

    // R1: 256-entry load
    depthSel = 3'd3;
    for (int i = 0; i < 256; i++)
      wordBuf[i] = {8'h01, 8'(i), ~8'(i), 8'(i) ^ 8'h5A};
    sendRange(0, 255);
    lookupCheck("R1", 255, 24'hFF00A5, 1'b1);
    lookupCheck("R1", 128, 24'h807FDA, 1'b1);
    lookupCheck("R1", 0, 24'h00FF5A, 1'b1);

    // R8 / R13: layout change rebuilds at frame start
    @(negedge clk);
    palFmtSel  = 2'd0;
    frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    checkVal("R8", "busy in rebuild", {31'h0, palBusy}, 32'h1);
    checkVal("R13", "ready in rebuild", {31'h0, wordReady}, 32'h0);
    lookupCheck("R10", 255, 24'hFF00A5, 1'b1);
    waitIdle();
    lookupCheck("R8", 255, 24'h001428, 1'b0);
    lookupCheck("R8", 0, 24'hF8E8D0, 1'b0);
    lookupCheck("R8", 128, 24'h78F8D0, 1'b0);

    // R12: one-cycle read latency
    @(negedge clk) lookupIdx = 8'd255;
    #1 checkVal("R12", "before edge", {8'h0, lookupRgb}, 32'h0078F8D0);
    @(negedge clk);
    checkVal("R12", "after edge", {8'h0, lookupRgb}, 32'h00001428);

    // R8: same layout, frame start ignored
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    checkVal("R8", "no rebuild", {31'h0, palBusy}, 32'h0);
    checkVal("R13", "ready idle", {31'h0, wordReady}, 32'h1);

    finishRun();
  end

endmodule